// File: doc/BRIEF.md
# Ethernet Control Frame Parser

This block watches a byte-wide receive stream from an Ethernet MAC and recognises the small control frames that a receiving host sends to a streaming data source. Each frame carries a private EtherType and a 16-bit command word. The block checks the destination address, the EtherType and the frame length. When a frame is good, it raises exactly one single-cycle command pulse: start transmission, stop transmission, or acknowledge. An acknowledge pulse also carries the set number and the packet index that the host is confirming.

When a start command is accepted, the block also latches the sender's MAC address. The frame builder uses that address as the destination of every data frame that follows. CRC checking is done upstream, and the MAC reports a bad frame through the error input. Any frame that carries that error flag is discarded.

The parser is built around a four-state machine:
- `ST_IDLE` waits for a start-of-frame byte.
- `ST_RECV` collects the header bytes.
- `ST_SKIP` discards the rest of a frame that has an error flag.
- `ST_DONE` lasts one cycle, after a clean end-of-frame, and evaluates the captured fields.

The transitions are:
- **begin**: from any state except `ST_RECV`, a valid byte with the start marker goes to `ST_RECV`. If that byte also ends the frame, it goes to `ST_DONE` instead. If that byte carries the error flag, it goes to `ST_SKIP`, or to `ST_IDLE` when the byte also ends the frame.
- **restart**: a start marker in `ST_RECV` takes the same path as begin, so the new frame replaces the one in progress.
- **abort**: the error flag in `ST_RECV` goes to `ST_SKIP`, or to `ST_IDLE` if it arrives on the last byte.
- **finish**: a clean last byte in `ST_RECV` goes to `ST_DONE`.
- **drain**: the last byte in `ST_SKIP` goes to `ST_IDLE`.
- **settle**: `ST_DONE` always leaves after one cycle, to `ST_IDLE`, or through begin when a new frame starts in that same cycle.

Top module: `ctrl_frame_parser`

## Requirements
- R1: After reset, all three command pulses are low, `peer_mac` is zero and `peer_mac_valid` is low.
- R2: A frame is accepted only if bytes 12 and 13 (first byte most significant) form the value 0xFADE.
- R3: A frame is accepted only if bytes 0 to 5 (byte 0 most significant) equal `local_mac` or equal all ones (broadcast).
- R4: An accepted frame whose bytes 14 and 15 (big-endian) are 0x0001 raises `start_pulse`.
- R5: An accepted frame whose opcode is 0x0005 raises `stop_pulse`.
- R6: An accepted frame whose opcode is 0x0003 raises `ack_pulse`. The 16-bit value in bytes 16 and 17 (big-endian) is split into `ack_set`, which is bits 15:5, and `ack_pkt`, which is bits 4:0. Both are valid while `ack_pulse` is high.
- R7: A command pulse is high for exactly one cycle: the cycle right after the clock edge that samples the end-of-frame byte. At most one pulse is high at any time.
- R8: If `rx_err` is high in any cycle of a frame, up to and including its last byte, that frame raises no pulse.
- R9: A frame shorter than 16 bytes raises no pulse. An acknowledge frame shorter than 18 bytes raises no pulse.
- R10: An opcode other than 0x0001, 0x0003 or 0x0005 raises no pulse and leaves `peer_mac` unchanged.
- R11: An accepted start frame loads its source address (bytes 6 to 11, byte 6 most significant) into `peer_mac` and sets `peer_mac_valid`, visible one cycle after `start_pulse`. Stop and acknowledge frames do not change `peer_mac`.
- R12: Bytes after byte 17 (the padding) have no effect. A start marker in the middle of a frame drops the partial frame and begins a new one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| local_mac | input | 48 | Own station address |
| rx_data | input | 8 | Received byte |
| rx_valid | input | 1 | `rx_data` holds a byte this cycle |
| rx_sof | input | 1 | First byte of a frame |
| rx_eof | input | 1 | Last byte of a frame |
| rx_err | input | 1 | MAC reports the current frame as bad |
| start_pulse | output | 1 | Start transmission command |
| stop_pulse | output | 1 | Stop transmission command |
| ack_pulse | output | 1 | Acknowledge command |
| ack_set | output | 11 | Set number of the acknowledged packet |
| ack_pkt | output | 5 | Index of the acknowledged packet |
| peer_mac | output | 48 | Latched address of the host |
| peer_mac_valid | output | 1 | `peer_mac` has been loaded |

## Verification
On every cycle, the assertions check four things:
- at most one command pulse is high;
- every pulse follows a cleanly sampled end-of-frame byte and lasts one cycle;
- `peer_mac` changes only right after a start pulse, and `peer_mac_valid` never falls;
- the byte counter never runs past the header.

Only the bench's scenarios can show that the right command is decoded. Its sweeps cover the address, EtherType, opcode, length, error position and sequence value, and they check that the acknowledge fields are split correctly and that a restarted or padded frame behaves as required.

// File: rtl/cfp_pkg.sv
package cfp_pkg;
    localparam int MAC_W         = 48;
    localparam int SEQ_W         = 16;
    localparam int HDR_BYTES     = 18;
    localparam int MIN_CMD_BYTES = 16;
    localparam int IDX_W         = $clog2(HDR_BYTES + 1);

    localparam logic [15:0] CTRL_ETYPE = 16'hFADE;
    localparam logic [15:0] OPC_START  = 16'h0001;
    localparam logic [15:0] OPC_ACK    = 16'h0003;
    localparam logic [15:0] OPC_STOP   = 16'h0005;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RECV,
        ST_SKIP,
        ST_DONE
    } cfp_state_e;
endpackage

// File: rtl/cfp_capture.sv
module cfp_capture
    import cfp_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             byte_en,
    input  logic             first,
    input  logic [7:0]       data,
    output logic [IDX_W-1:0] count,
    output logic [MAC_W-1:0] dst,
    output logic [MAC_W-1:0] src,
    output logic [15:0]      etype,
    output logic [15:0]      opc,
    output logic [SEQ_W-1:0] seq
);
    logic [IDX_W-1:0] pos;
    assign pos = first ? '0 : count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
            dst   <= '0;
            src   <= '0;
            etype <= '0;
            opc   <= '0;
            seq   <= '0;
        end else if (byte_en) begin
            if (pos < IDX_W'(HDR_BYTES))
                count <= pos + IDX_W'(1);
            else
                count <= pos;
            if (pos < IDX_W'(6))
                dst <= {dst[MAC_W-9:0], data};
            else if (pos < IDX_W'(12))
                src <= {src[MAC_W-9:0], data};
            else if (pos < IDX_W'(14))
                etype <= {etype[7:0], data};
            else if (pos < IDX_W'(16))
                opc <= {opc[7:0], data};
            else if (pos < IDX_W'(HDR_BYTES))
                seq <= {seq[SEQ_W-9:0], data};
        end
    end

    // R12
    cnt_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= IDX_W'(HDR_BYTES));
endmodule

// File: rtl/cfp_fsm.sv
module cfp_fsm
    import cfp_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rx_valid,
    input  logic rx_sof,
    input  logic rx_eof,
    input  logic rx_err,
    output logic byte_en,
    output logic eval
);
    cfp_state_e state, nxt, begin_st;
    logic       start_new, last_byte;

    assign start_new = rx_valid && rx_sof;
    assign last_byte = rx_valid && rx_eof;

    always_comb begin
        if (rx_err)
            begin_st = last_byte ? ST_IDLE : ST_SKIP;
        else
            begin_st = last_byte ? ST_DONE : ST_RECV;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (start_new) nxt = begin_st;
            end
            ST_RECV: begin
                if (start_new)
                    nxt = begin_st;
                else if (rx_err)
                    nxt = last_byte ? ST_IDLE : ST_SKIP;
                else if (last_byte)
                    nxt = ST_DONE;
            end
            ST_SKIP: begin
                if (start_new)
                    nxt = begin_st;
                else if (last_byte)
                    nxt = ST_IDLE;
            end
            ST_DONE: begin
                nxt = start_new ? begin_st : ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        byte_en = rx_valid && (rx_sof || state == ST_RECV);
        eval    = (state == ST_DONE);
    end

    // R8
    skip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SKIP && !rx_valid) |=> state == ST_SKIP);
endmodule

// File: rtl/cfp_decode.sv
module cfp_decode
    import cfp_pkg::*;
(
    input  logic             eval,
    input  logic [IDX_W-1:0] count,
    input  logic [MAC_W-1:0] local_mac,
    input  logic [MAC_W-1:0] dst,
    input  logic [15:0]      etype,
    input  logic [15:0]      opc,
    output logic             cmd_start,
    output logic             cmd_stop,
    output logic             cmd_ack
);
    logic addr_ok, hdr_ok;

    always_comb begin
        addr_ok   = (dst == local_mac) || (&dst);
        hdr_ok    = eval && addr_ok && (etype == CTRL_ETYPE) &&
                    (count >= IDX_W'(MIN_CMD_BYTES));
        cmd_start = hdr_ok && (opc == OPC_START);
        cmd_stop  = hdr_ok && (opc == OPC_STOP);
        cmd_ack   = hdr_ok && (opc == OPC_ACK) &&
                    (count >= IDX_W'(HDR_BYTES));
    end
endmodule

// File: rtl/ctrl_frame_parser.sv
module ctrl_frame_parser
    import cfp_pkg::*;
#(
    parameter int PKT_BITS = 5,
    localparam int SET_BITS = SEQ_W - PKT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [MAC_W-1:0]    local_mac,
    input  logic [7:0]          rx_data,
    input  logic                rx_valid,
    input  logic                rx_sof,
    input  logic                rx_eof,
    input  logic                rx_err,
    output logic                start_pulse,
    output logic                stop_pulse,
    output logic                ack_pulse,
    output logic [SET_BITS-1:0] ack_set,
    output logic [PKT_BITS-1:0] ack_pkt,
    output logic [MAC_W-1:0]    peer_mac,
    output logic                peer_mac_valid
);
    logic             byte_en, eval;
    logic [IDX_W-1:0] count;
    logic [MAC_W-1:0] dst, src;
    logic [15:0]      etype, opc;
    logic [SEQ_W-1:0] seq;

    cfp_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_sof(rx_sof),
        .rx_eof(rx_eof), .rx_err(rx_err), .byte_en(byte_en), .eval(eval)
    );

    cfp_capture u_cap (
        .clk(clk), .rst_n(rst_n), .byte_en(byte_en), .first(rx_sof),
        .data(rx_data), .count(count), .dst(dst), .src(src),
        .etype(etype), .opc(opc), .seq(seq)
    );

    cfp_decode u_dec (
        .eval(eval), .count(count), .local_mac(local_mac), .dst(dst),
        .etype(etype), .opc(opc), .cmd_start(start_pulse),
        .cmd_stop(stop_pulse), .cmd_ack(ack_pulse)
    );

    assign ack_set = seq[SEQ_W-1:PKT_BITS];
    assign ack_pkt = seq[PKT_BITS-1:0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            peer_mac       <= '0;
            peer_mac_valid <= 1'b0;
        end else if (start_pulse) begin
            peer_mac       <= src;
            peer_mac_valid <= 1'b1;
        end
    end

    // R7
    one_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({start_pulse, stop_pulse, ack_pulse}));

    // R7
    after_eof_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || stop_pulse || ack_pulse) |->
            $past(rx_valid && rx_eof && !rx_err));

    // R7
    single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_pulse || stop_pulse || ack_pulse) |=>
            !(start_pulse || stop_pulse || ack_pulse) || $past(rx_sof && rx_eof));

    // R11
    peer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(start_pulse) |-> $stable(peer_mac));

    // R11
    valid_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(peer_mac_valid) |-> peer_mac_valid);
endmodule

// File: tb/sim_ctrl_frame_parser.sv
module sim_ctrl_frame_parser;
    localparam logic [47:0] LOCAL = 48'h02_00_5E_10_20_31;
    localparam logic [47:0] BCAST = 48'hFFFF_FFFF_FFFF;
    localparam logic [47:0] SRC_A = 48'h0A_1B_2C_3D_4E_5F;
    localparam logic [47:0] SRC_B = 48'h66_77_88_99_AA_BB;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_valid = 1'b0, rx_sof = 1'b0, rx_eof = 1'b0, rx_err = 1'b0;
    logic        start_pulse, stop_pulse, ack_pulse, peer_mac_valid;
    logic [10:0] ack_set;
    logic [4:0]  ack_pkt;
    logic [47:0] peer_mac;

    int checks = 0;
    int errors = 0;
    logic [47:0] exp_peer = '0;
    logic        exp_pvalid = 1'b0;

    always #2.5 clk = ~clk;

    ctrl_frame_parser u0 (
        .clk(clk), .rst_n(rst_n), .local_mac(LOCAL), .rx_data(rx_data),
        .rx_valid(rx_valid), .rx_sof(rx_sof), .rx_eof(rx_eof), .rx_err(rx_err),
        .start_pulse(start_pulse), .stop_pulse(stop_pulse), .ack_pulse(ack_pulse),
        .ack_set(ack_set), .ack_pkt(ack_pkt), .peer_mac(peer_mac),
        .peer_mac_valid(peer_mac_valid)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] fbyte(input logic [47:0] d, input logic [47:0] s,
                                         input logic [15:0] et, input logic [15:0] op,
                                         input logic [15:0] sq, input int i);
        if (i < 6)       return d[47-8*i -: 8];
        else if (i < 12) return s[47-8*(i-6) -: 8];
        else if (i == 12) return et[15:8];
        else if (i == 13) return et[7:0];
        else if (i == 14) return op[15:8];
        else if (i == 15) return op[7:0];
        else if (i == 16) return sq[15:8];
        else if (i == 17) return sq[7:0];
        else             return 8'(i) ^ 8'h5A;
    endfunction

    task automatic drive_bytes(input logic [47:0] d, input logic [47:0] s,
                               input logic [15:0] et, input logic [15:0] op,
                               input logic [15:0] sq, input int len,
                               input int err_at, input bit with_eof);
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            rx_valid = 1'b1;
            rx_sof   = (i == 0);
            rx_eof   = with_eof && (i == len - 1);
            rx_err   = (i == err_at);
            rx_data  = fbyte(d, s, et, op, sq, i);
        end
    endtask

    task automatic frame(input string req, input logic [47:0] d, input logic [47:0] s,
                         input logic [15:0] et, input logic [15:0] op,
                         input logic [15:0] sq, input int len, input int err_at);
        bit ok, e_start, e_stop, e_ack;
        ok = ((d == LOCAL) || (d == BCAST)) && (et == 16'hFADE) && (len >= 16) &&
             !(err_at >= 0 && err_at < len);
        e_start = ok && op == 16'h0001;
        e_stop  = ok && op == 16'h0005;
        e_ack   = ok && op == 16'h0003 && len >= 18;
        drive_bytes(d, s, et, op, sq, len, err_at, 1'b1);
        @(negedge clk);
        rx_valid = 1'b0; rx_sof = 1'b0; rx_eof = 1'b0; rx_err = 1'b0;
        check({req, " start"}, 64'(start_pulse), 64'(e_start));
        check({req, " stop"}, 64'(stop_pulse), 64'(e_stop));
        check({req, " ack"}, 64'(ack_pulse), 64'(e_ack));
        if (e_ack) begin
            check({req, " ack_set R6"}, 64'(ack_set), 64'(sq >> 5));
            check({req, " ack_pkt R6"}, 64'(ack_pkt), 64'(sq & 16'h1F));
        end
        if (e_start) begin exp_peer = s; exp_pvalid = 1'b1; end
        @(negedge clk);
        check({req, " pulse width R7"}, 64'({start_pulse, stop_pulse, ack_pulse}), 64'd0);
        check({req, " peer R11"}, 64'(peer_mac), 64'(exp_peer));
        check({req, " peer valid R11"}, 64'(peer_mac_valid), 64'(exp_pvalid));
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 start", 64'(start_pulse), 64'd0);
        check("R1 stop", 64'(stop_pulse), 64'd0);
        check("R1 ack", 64'(ack_pulse), 64'd0);
        check("R1 peer", 64'(peer_mac), 64'd0);
        check("R1 peer valid", 64'(peer_mac_valid), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 R4 R5 R6: opcode sweep, stop/ack/unknown before any start
        for (int op = 0; op < 8; op++)
            if (op != 1) frame("R10 opcode", LOCAL, SRC_B, 16'hFADE, 16'(op), 16'(op * 613), 64, -1);
        frame("R4 start", LOCAL, SRC_A, 16'hFADE, 16'h0001, 16'h0, 64, -1);
        for (int op = 0; op < 8; op++)
            frame("R5 R6 opcode", LOCAL, SRC_B, 16'hFADE, 16'(op), 16'(op * 613 + 7), 64, -1);
        frame("R10 high opcode", LOCAL, SRC_B, 16'hFADE, 16'h0103, 16'h0, 64, -1);

        // R2: EtherType variants
        begin
            logic [15:0] ets [5] = '{16'hFADE, 16'hFADF, 16'hDEFA, 16'h0800, 16'h7ADE};
            foreach (ets[k]) frame("R2 ethertype", LOCAL, SRC_B, ets[k], 16'h0003, 16'h0042, 64, -1);
        end

        // R3: destination variants
        frame("R3 local", LOCAL, SRC_B, 16'hFADE, 16'h0005, 16'h0, 64, -1);
        frame("R3 broadcast", BCAST, SRC_B, 16'hFADE, 16'h0005, 16'h0, 64, -1);
        for (int b = 0; b < 48; b += 7)
            frame("R3 bitflip", LOCAL ^ (48'd1 << b), SRC_B, 16'hFADE, 16'h0005, 16'h0, 64, -1);

        // R9 R12: length sweep
        for (int len = 1; len <= 22; len++) begin
            frame("R9 ack length", LOCAL, SRC_B, 16'hFADE, 16'h0003, 16'hABCD, len, -1);
            frame("R9 stop length", BCAST, SRC_B, 16'hFADE, 16'h0005, 16'h0, len, -1);
        end

        // R8: error position sweep
        for (int e = 0; e < 64; e += 9)
            frame("R8 error", LOCAL, SRC_B, 16'hFADE, 16'h0003, 16'h1111, 64, e);
        frame("R8 error last", LOCAL, SRC_B, 16'hFADE, 16'h0003, 16'h1111, 64, 63);

        // R6: sequence value sweep
        for (int k = 0; k < 16; k++)
            frame("R6 seq", LOCAL, SRC_B, 16'hFADE, 16'h0003, 16'((k * 4099) ^ (k << 12)), 20, -1);
        frame("R6 seq max", LOCAL, SRC_B, 16'hFADE, 16'h0003, 16'hFFFF, 64, -1);

        // R11: new start reloads address
        frame("R11 restart", BCAST, SRC_B, 16'hFADE, 16'h0001, 16'h0, 64, -1);
        frame("R11 after", LOCAL, SRC_A, 16'hFADE, 16'h0003, 16'h0020, 64, -1);

        // R12: mid-frame start marker drops partial frame
        drive_bytes(LOCAL, SRC_A, 16'hFADE, 16'h0001, 16'h0, 15, -1, 1'b0);
        frame("R12 restart", LOCAL, SRC_B, 16'hFADE, 16'h0005, 16'h0, 64, -1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule